// File: doc/BRIEF.md
# Boot Vector Fetch Sequencer

This block runs once after reset is released and brings a core up to the point where it can execute. It makes two word reads, one after the other, on a simple memory port that uses valid/ready handshakes. The first read is from address 0x00000000. Its data, aligned to a word, becomes the initial stack pointer. The second read is from address 0x00000004. It returns the reset vector.

If the vector word holds the erased all-ones pattern, the flash has never been programmed, and startup goes to a fixed boot-ROM loader entry address. Otherwise the vector, with its lowest bit cleared, is the start address. The sequencer then drives the start address and a boot-ROM-selected flag, and raises a one-cycle start strobe. After that it stays quiet until the next reset.

The core holds off execution until the strobe arrives. It then takes the stack pointer and start address from the outputs, which keep their values afterwards.

Top module: `boot_vector_seq`

## Requirements
- R1: After synchronous reset is released, the first request raised on the memory port has address 0x00000000.
- R2: The data word accepted for the first request is presented on `init_sp` with bits [1:0] forced to zero.
- R3: While the first response has not been accepted, no second request is raised and `mem_req_valid` is never high together with `mem_rsp_ready`. After that response is accepted, the next request has address 0x00000004.
- R4: When the second word is not 0xFFFFFFFF, `start_pc` equals that word with bit 0 cleared, and `rom_boot` is 0.
- R5: When the second word equals 0xFFFFFFFF, `start_pc` equals the boot-ROM entry parameter (0x01000000 by default), and `rom_boot` is 1.
- R6: `start_pulse` is high for exactly one cycle per reset, in the cycle after the second response is accepted and with `start_pc`, `rom_boot` and `init_sp` already valid. After that no request and no further pulse appear until reset.
- R7: While reset is held, `mem_req_valid`, `mem_rsp_ready`, `start_pulse`, `rom_boot`, `init_sp` and `start_pc` are all 0.
- R8: A request holds `mem_req_valid` and an unchanged address until `mem_req_ready` is seen. A response offered while `mem_rsp_ready` is low is ignored and does not reach `init_sp` or `start_pc`.
- R9: The near-erased vector 0xFFFFFFFE counts as a normal vector: `start_pc` is 0xFFFFFFFE and `rom_boot` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Read request word address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_ready | output | 1 | Sequencer accepts read data |
| mem_rsp_data | input | 32 | Read data word |
| init_sp | output | 32 | Initial stack pointer, word aligned |
| start_pc | output | 32 | Address where execution begins |
| rom_boot | output | 1 | Start address is the boot-ROM entry |
| start_pulse | output | 1 | One-cycle strobe: start the core |

## Verification
A control state that skips a step or repeats one shows up on the memory port within a cycle or two. Examples are a second request raised while the first response is still outstanding, an address other than 0 or 4, or a request after the strobe. A wrong capture or a wrong decision on the vector word shows up only at the strobe. In that cycle the scoreboard compares `init_sp`, `start_pc` and `rom_boot` with values computed from the words it served. A duplicated or missing strobe appears as a pulse count other than one for each reset.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;
  typedef enum logic [2:0] {
    BS_IDLE,
    BS_REQ_SP,
    BS_WAIT_SP,
    BS_REQ_VEC,
    BS_WAIT_VEC,
    BS_DONE
  } bs_state_t;
endpackage

// File: rtl/bvs_fetch_ctrl.sv
module bvs_fetch_ctrl
  import boot_seq_pkg::*;
#(
  parameter int          AW       = 32,
  parameter logic [AW-1:0] SP_ADDR  = '0,
  parameter logic [AW-1:0] VEC_ADDR = AW'(4)
) (
  input  logic          clk,
  input  logic          rst,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [AW-1:0] req_addr,
  input  logic          rsp_valid,
  output logic          rsp_ready,
  output logic          take_sp,
  output logic          take_vec
);
  bs_state_t state_q;
  logic      req_valid_q;
  logic      rsp_ready_q;
  logic [AW-1:0] req_addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= BS_IDLE;
      req_valid_q <= 1'b0;
      rsp_ready_q <= 1'b0;
      req_addr_q  <= '0;
    end else begin
      unique case (state_q)
        BS_IDLE: begin
          req_valid_q <= 1'b1;
          req_addr_q  <= SP_ADDR;
          state_q     <= BS_REQ_SP;
        end
        BS_REQ_SP: if (req_ready) begin
          req_valid_q <= 1'b0;
          rsp_ready_q <= 1'b1;
          state_q     <= BS_WAIT_SP;
        end
        BS_WAIT_SP: if (rsp_valid) begin
          rsp_ready_q <= 1'b0;
          req_valid_q <= 1'b1;
          req_addr_q  <= VEC_ADDR;
          state_q     <= BS_REQ_VEC;
        end
        BS_REQ_VEC: if (req_ready) begin
          req_valid_q <= 1'b0;
          rsp_ready_q <= 1'b1;
          state_q     <= BS_WAIT_VEC;
        end
        BS_WAIT_VEC: if (rsp_valid) begin
          rsp_ready_q <= 1'b0;
          state_q     <= BS_DONE;
        end
        default: begin
          req_valid_q <= 1'b0;
          rsp_ready_q <= 1'b0;
          state_q     <= BS_DONE;
        end
      endcase
    end
  end

  assign req_valid = req_valid_q;
  assign rsp_ready = rsp_ready_q;
  assign req_addr  = req_addr_q;
  assign take_sp   = (state_q == BS_WAIT_SP)  && rsp_valid && rsp_ready_q;
  assign take_vec  = (state_q == BS_WAIT_VEC) && rsp_valid && rsp_ready_q;

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)));

  // R3
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> !rsp_ready);

  // R3
  vec_after_sp_chk: assert property (@(posedge clk) disable iff (rst)
    take_sp |=> (req_valid && req_addr == VEC_ADDR));
endmodule

// File: rtl/bvs_sp_capture.sv
module bvs_sp_capture #(
  parameter int DW       = 32,
  parameter int SP_ALIGN = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  logic [DW-1:0] word,
  output logic [DW-1:0] sp
);
  logic [DW-1:0] sp_q;

  always_ff @(posedge clk) begin
    if (rst)       sp_q <= '0;
    else if (take) sp_q <= {word[DW-1:SP_ALIGN], SP_ALIGN'(0)};
  end

  assign sp = sp_q;
endmodule

// File: rtl/bvs_vector_decode.sv
module bvs_vector_decode #(
  parameter int            AW        = 32,
  parameter int            DW        = 32,
  parameter logic [AW-1:0] ROM_ENTRY = 32'h0100_0000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  logic [DW-1:0] word,
  output logic [AW-1:0] start_pc,
  output logic          rom_boot,
  output logic          start_pulse
);
  localparam logic [DW-1:0] ERASED = '1;

  logic          erased;
  logic [AW-1:0] pc_q;
  logic          rom_q;
  logic          pulse_q;

  assign erased = (word == ERASED);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q    <= '0;
      rom_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= take;
      if (take) begin
        rom_q <= erased;
        pc_q  <= erased ? ROM_ENTRY : {AW'(word[DW-1:1]), 1'b0};
      end
    end
  end

  assign start_pc    = pc_q;
  assign rom_boot    = rom_q;
  assign start_pulse = pulse_q;

  // R6
  pulse_once_chk: assert property (@(posedge clk) disable iff (rst)
    start_pulse |=> !start_pulse);

  // R5
  rom_pc_chk: assert property (@(posedge clk) disable iff (rst)
    (start_pulse && rom_boot) |-> (start_pc == ROM_ENTRY));

  // R4
  vec_align_chk: assert property (@(posedge clk) disable iff (rst)
    (start_pulse && !rom_boot) |-> !start_pc[0]);
endmodule

// File: rtl/boot_vector_seq.sv
module boot_vector_seq #(
  parameter int            AW        = 32,
  parameter int            DW        = 32,
  parameter int            SP_ALIGN  = 2,
  parameter logic [AW-1:0] SP_ADDR   = '0,
  parameter logic [AW-1:0] VEC_ADDR  = AW'(4),
  parameter logic [AW-1:0] ROM_ENTRY = 32'h0100_0000
) (
  input  logic          clk,
  input  logic          rst,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_addr,
  input  logic          mem_rsp_valid,
  output logic          mem_rsp_ready,
  input  logic [DW-1:0] mem_rsp_data,
  output logic [DW-1:0] init_sp,
  output logic [AW-1:0] start_pc,
  output logic          rom_boot,
  output logic          start_pulse
);
  logic take_sp;
  logic take_vec;

  bvs_fetch_ctrl #(.AW(AW), .SP_ADDR(SP_ADDR), .VEC_ADDR(VEC_ADDR)) u_ctrl (
    .clk(clk), .rst(rst),
    .req_valid(mem_req_valid), .req_ready(mem_req_ready), .req_addr(mem_req_addr),
    .rsp_valid(mem_rsp_valid), .rsp_ready(mem_rsp_ready),
    .take_sp(take_sp), .take_vec(take_vec)
  );

  bvs_sp_capture #(.DW(DW), .SP_ALIGN(SP_ALIGN)) u_sp (
    .clk(clk), .rst(rst), .take(take_sp), .word(mem_rsp_data), .sp(init_sp)
  );

  bvs_vector_decode #(.AW(AW), .DW(DW), .ROM_ENTRY(ROM_ENTRY)) u_vec (
    .clk(clk), .rst(rst), .take(take_vec), .word(mem_rsp_data),
    .start_pc(start_pc), .rom_boot(rom_boot), .start_pulse(start_pulse)
  );

  // R6
  quiet_after_chk: assert property (@(posedge clk) disable iff (rst)
    start_pulse |=> !mem_req_valid);
endmodule

// File: tb/boot_vector_seq_bench.sv
module boot_vector_seq_bench;
  localparam logic [31:0] ROM = 32'h0100_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mem_req_valid, mem_rsp_ready, rom_boot, start_pulse;
  logic        mem_req_ready = 1'b0;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_req_addr, init_sp, start_pc;
  logic [31:0] mem_rsp_data = '0;

  typedef struct { logic [31:0] sp; logic [31:0] pc; logic rom; } exp_t;
  exp_t exp_q[$];

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  bit done = 0;

  always #10 clk = ~clk;

  boot_vector_seq u_boot_vector_seq (
    .clk(clk), .rst(rst),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data),
    .init_sp(init_sp), .start_pc(start_pc), .rom_boot(rom_boot), .start_pulse(start_pulse)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected results at each start strobe
  always @(negedge clk) begin
    if (!rst && start_pulse) begin
      pulses++;
      if (exp_q.size() == 0) begin
        check(1'b0, "R6 unexpected start pulse", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(init_sp == e.sp, "R2 init_sp", init_sp, e.sp);
        check(start_pc == e.pc, e.rom ? "R5 start_pc" : "R4 start_pc", start_pc, e.pc);
        check(rom_boot == e.rom, e.rom ? "R5 rom_boot" : "R4 rom_boot", 32'(rom_boot), 32'(e.rom));
      end
    end
  end

  task automatic wait_req(input logic [31:0] addr, input string tag);
    int n = 0;
    while (!mem_req_valid && n < 20) begin
      @(negedge clk);
      n++;
    end
    check(mem_req_valid, {tag, " request raised"}, 32'(mem_req_valid), 32'd1);
    check(mem_req_addr == addr, {tag, " request address"}, mem_req_addr, addr);
  endtask

  task automatic do_run(input logic [31:0] sp_w, input logic [31:0] vec_w,
                        input int ready_wait, input int rsp_wait, input bit junk);
    exp_t e;
    e.sp  = sp_w & 32'hFFFF_FFFC;
    e.rom = (vec_w == 32'hFFFF_FFFF);
    e.pc  = e.rom ? ROM : (vec_w & 32'hFFFF_FFFE);
    exp_q.push_back(e);
    pulses = 0;

    @(negedge clk);
    rst = 1'b1;
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    repeat (3) @(negedge clk);
    // R7 reset state
    check(!mem_req_valid && !mem_rsp_ready && !start_pulse && !rom_boot,
          "R7 control outputs in reset", {28'd0, mem_req_valid, mem_rsp_ready, start_pulse, rom_boot}, 32'd0);
    check(init_sp == 0 && start_pc == 0, "R7 data outputs in reset", init_sp | start_pc, 32'd0);
    rst = 1'b0;

    // first request
    wait_req(32'h0, "R1");
    if (junk) begin
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = 32'hDEAD_BEEF;
    end
    for (int i = 0; i < ready_wait; i++) begin
      @(negedge clk);
      check(mem_req_valid && mem_req_addr == 32'h0, "R8 request held", mem_req_addr, 32'h0);
    end
    mem_rsp_valid = 1'b0;
    mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0;
    check(!mem_req_valid && mem_rsp_ready, "R3 awaiting first response",
          {30'd0, mem_req_valid, mem_rsp_ready}, 32'd1);
    for (int i = 0; i < rsp_wait; i++) begin
      @(negedge clk);
      check(!mem_req_valid, "R3 no second request early", 32'(mem_req_valid), 32'd0);
    end
    mem_rsp_valid = 1'b1;
    mem_rsp_data  = sp_w;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = 32'h5A5A_5A5A;

    // second request
    wait_req(32'h4, "R3");
    repeat (ready_wait) @(negedge clk);
    mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0;
    repeat (rsp_wait) @(negedge clk);
    mem_rsp_valid = 1'b1;
    mem_rsp_data  = vec_w;
    @(negedge clk);          // pulse visible here; monitor samples it
    mem_rsp_valid = 1'b0;
    @(negedge clk);
    check(!start_pulse, "R6 pulse one cycle wide", 32'(start_pulse), 32'd0);
    for (int i = 0; i < 6; i++) begin
      mem_req_ready = 1'b1;
      @(negedge clk);
      if (mem_req_valid) check(1'b0, "R6 request after start", 32'd1, 32'd0);
    end
    mem_req_ready = 1'b0;
    check(pulses == 1, "R6 pulse count", 32'(pulses), 32'd1);
    check(exp_q.size() == 0, "R6 expected result consumed", 32'(exp_q.size()), 32'd0);
  endtask

  initial begin
    do_run(32'h2000_1237, 32'h0000_0401, 0, 0, 1'b0);  // R4 R2
    do_run(32'h2000_FFFF, 32'hFFFF_FFFF, 2, 3, 1'b0);  // R5
    do_run(32'h2000_8000, 32'hFFFF_FFFE, 1, 1, 1'b0);  // R9 boundary
    do_run(32'h1000_0002, 32'h1234_5679, 4, 2, 1'b1);  // R8 junk response ignored
    do_run(32'hFFFF_FFFF, 32'h0000_0000, 0, 5, 1'b1);  // R4 zero vector
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=0", 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule